// File: doc/BRIEF.md
# Clocked Synchronous Serial Shifter

This block is a master-side byte shifter for a clock-synchronous serial link. A start strobe captures a parallel byte. The block then produces its own transfer clock by dividing the system clock. It drives the byte out one bit per transfer-clock period on a serial output. In the same periods it samples a serial input and assembles the received byte. A one-cycle completion pulse marks the moment the received byte is ready.

Static configuration inputs set four things. The first is the clock polarity, which fixes the idle level and which edge launches or captures data. The second is whether the least or the most significant bit travels first. The third is whether both data lines carry inverted logic levels. The fourth is which of two clock output pins carries the transfer clock. The configuration is followed live while the block is idle and is frozen from the accepted start until the completion pulse.

Top module: `sync_serial_shifter`

## Requirements
- R1: Every accepted transfer moves exactly 8 bits: 8 launching and 8 capturing clock edges. `busy` stays high for exactly 16*(div_half+1) system cycles. `busy` is low in the cycle that `done` is high.
- R2: Each half period of the transfer clock lasts div_half+1 system clock cycles. The first launching edge appears div_half+1 cycles after the start is accepted.
- R3: With `cfg_pol`=0 the clock idles high, data changes on the falling edge and input is sampled on the rising edge. With `cfg_pol`=1 the clock idles low, data changes on the rising edge and input is sampled on the falling edge. `sdo` changes only on a launching edge.
- R4: With `cfg_msb_first`=0, bit 0 of the byte is sent first and bit 7 last. The first bit received is stored in bit 0 of `rx_byte`.
- R5: With `cfg_msb_first`=1, bit 7 is sent first. The first bit received is stored in bit 7 of `rx_byte`, and later bits fill downward.
- R6: With `cfg_invert`=1, every bit driven on `sdo` is the complement of the data bit, and every sampled `sdi` bit is complemented before it is stored.
- R7: With `cfg_multi_pin`=0 the clock is driven on `sclk_a`. With `cfg_multi_pin`=1, `cfg_pin_sel`=0 selects `sclk_a` and `cfg_pin_sel`=1 selects `sclk_b`. The unselected pin holds the idle level, and both pins idle when no transfer runs.
- R8: `done` is high for exactly one system cycle, starting one cycle after the register edge that takes the eighth sample. `rx_byte` holds the received byte from then until the next transfer.
- R9: A start request while `busy` is high is ignored: the running transfer keeps its byte and its timing.
- R10: After reset, `sdo`=1, both clock pins sit at the idle level, and `busy`, `done` and `rx_byte` are 0. Between transfers `sdo` keeps the last bit it drove.
- R11: A start presented in the cycle that `done` is high is accepted, so a new transfer begins with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a transfer; sampled when idle |
| tx_byte | input | DATA_W | Byte to transmit, captured on an accepted start |
| div_half | input | DIV_W | Half period of the transfer clock minus one, in system cycles |
| cfg_pol | input | 1 | Clock polarity select |
| cfg_msb_first | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| cfg_invert | input | 1 | Invert logic level on both data lines |
| cfg_multi_pin | input | 1 | Enable choice of clock output pin |
| cfg_pin_sel | input | 1 | Clock pin choice when enabled: 0 sclk_a, 1 sclk_b |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sclk_a | output | 1 | First transfer clock pin |
| sclk_b | output | 1 | Second transfer clock pin |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | DATA_W | Received byte |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle: `busy` has already dropped while `done` is still high. The bench provokes this by raising `start` at the very cycle it sees `done`. It judges the result by requiring `busy` one cycle later and a second, complete and correct transfer with no gap. The opposite pairing, a start that lands mid-transfer, is also driven. There the bench requires that the bits sent still match the first byte and that the cycle count is unchanged.

// File: rtl/sss_pkg.sv
// Package: shared configuration type for the serial shifter.
// Assumes: all fields are single-bit static controls.
package sss_pkg;
    typedef struct packed {
        logic pol;
        logic msb_first;
        logic invert;
        logic multi_pin;
        logic pin_sel;
    } sss_cfg_t;
endpackage

// File: rtl/sss_divider.sv
// Transfer-clock divider: emits a one-cycle tick every div_half+1 cycles
// while running. Assumes: load and run are never high together; the
// divide value is captured on load and held for the whole transfer.
module sss_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;

    assign tick = run && (cnt_q == '0);

    // Count down one half period, reloading from the captured divide value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= '0;
        end else if (load) begin
            cnt_q <= div_half;
            div_q <= div_half;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? div_q : cnt_q - 1'b1;
        end
    end

    // R2: the count never exceeds the captured half-period value.
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div_q));
endmodule

// File: rtl/sss_bit_engine.sv
// Bit engine: launches transmit bits and stores received bits in the
// chosen order, applying the optional level inversion on both lines.
// Assumes: drive and sample alternate, drive first, DATA_W of each per load.
module sss_bit_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              msb_first,
    input  logic              invert,
    input  logic              drive,
    input  logic              sample,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_byte,
    output logic              last_sample
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_q;
    logic [IDX_W-1:0]  drv_idx;
    logic [IDX_W-1:0]  smp_idx;

    // Map a transfer position to a byte bit position for the chosen order.
    function automatic logic [IDX_W-1:0] map_pos(input logic [IDX_W-1:0] i,
                                                  input logic msb);
        return msb ? (LAST_IDX - i) : i;
    endfunction

    assign last_sample = sample && (smp_idx == LAST_IDX);

    // Hold the transmit byte and track how many bits have been launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            drv_idx <= '0;
        end else if (load) begin
            tx_q    <= tx_byte;
            drv_idx <= '0;
        end else if (drive) begin
            drv_idx <= drv_idx + 1'b1;
        end
    end

    // Drive the next data bit on a launching edge; otherwise hold the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b1;
        end else if (drive) begin
            sdo <= tx_q[map_pos(drv_idx, msb_first)] ^ invert;
        end
    end

    // Store each sampled input bit at its mapped position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
            smp_idx <= '0;
        end else if (load) begin
            smp_idx <= '0;
        end else if (sample) begin
            rx_byte[map_pos(smp_idx, msb_first)] <= sdi ^ invert;
            smp_idx <= smp_idx + 1'b1;
        end
    end

    // R3: every capture comes exactly one launch after the previous capture.
    p_launch_before_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (drv_idx == IDX_W'(smp_idx + 1'b1)));
endmodule

// File: rtl/sss_clk_route.sv
// Clock router: forms the pin level from the phase and polarity and sends
// it to one of two output pins; the other pin holds the idle level.
// Assumes: phase is 0 whenever no transfer is active.
module sss_clk_route (
    input  logic active,
    input  logic phase,
    input  logic pol,
    input  logic multi_pin,
    input  logic pin_sel,
    output logic sclk_a,
    output logic sclk_b
);
    logic idle_lvl;
    logic run_lvl;
    logic use_b;

    // Pick the pin and its level from the current configuration.
    always_comb begin
        idle_lvl = ~pol;
        run_lvl  = idle_lvl ^ (active & phase);
        use_b    = multi_pin & pin_sel;
        sclk_a   = use_b ? idle_lvl : run_lvl;
        sclk_b   = use_b ? run_lvl  : idle_lvl;
    end
endmodule

// File: rtl/sync_serial_shifter.sv
// Top: master-mode clock-synchronous byte shifter. Sequences 2*DATA_W
// half periods per transfer, leading edges launch and trailing edges
// capture. Assumes: configuration is stable for the cycle of a start.
module sync_serial_shifter
    import sss_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              cfg_pol,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic              cfg_multi_pin,
    input  logic              cfg_pin_sel,
    input  logic              sdi,
    output logic              sdo,
    output logic              sclk_a,
    output logic              sclk_b,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    sss_cfg_t cfg_live;
    sss_cfg_t cfg_q;
    sss_cfg_t cfg_act;
    logic     phase_q;
    logic     tick;
    logic     accept;
    logic     lead;
    logic     trail;
    logic     last;

    // Gather live controls; freeze them while a transfer runs.
    always_comb begin
        cfg_live = '{pol: cfg_pol, msb_first: cfg_msb_first, invert: cfg_invert,
                     multi_pin: cfg_multi_pin, pin_sel: cfg_pin_sel};
        cfg_act  = busy ? cfg_q : cfg_live;
        accept   = start && !busy;
        lead     = tick && !phase_q;
        trail    = tick && phase_q;
    end

    // Transfer sequencer: busy flag, clock phase and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            phase_q <= 1'b0;
            done    <= 1'b0;
            cfg_q   <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                phase_q <= 1'b0;
                cfg_q   <= cfg_live;
            end else if (busy && tick) begin
                phase_q <= ~phase_q;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    sss_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .run      (busy),
        .div_half (div_half),
        .tick     (tick)
    );

    sss_bit_engine #(.DATA_W(DATA_W)) u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .tx_byte     (tx_byte),
        .msb_first   (cfg_act.msb_first),
        .invert      (cfg_act.invert),
        .drive       (lead),
        .sample      (trail),
        .sdi         (sdi),
        .sdo         (sdo),
        .rx_byte     (rx_byte),
        .last_sample (last)
    );

    sss_clk_route u_route (
        .active    (busy),
        .phase     (phase_q),
        .pol       (cfg_act.pol),
        .multi_pin (cfg_act.multi_pin),
        .pin_sel   (cfg_act.pin_sel),
        .sclk_a    (sclk_a),
        .sclk_b    (sclk_b)
    );

    // R8: completion lasts a single cycle.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1: the transfer is over when completion is flagged.
    p_done_not_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: a start during a running transfer does not end or restart it.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> busy);
    // R11: a start alongside completion launches the next transfer.
    p_back_to_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> busy);
    // R10: the data line holds while idle and no transfer is requested.
    p_sdo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(sdo));
    // R7: both pins sit at the idle level when no transfer runs.
    p_pins_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk_a == ~cfg_pol && sclk_b == ~cfg_pol));
    // R7: at most one pin ever leaves the idle level.
    p_one_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sclk_a ^ ~cfg_act.pol, sclk_b ^ ~cfg_act.pol}));
endmodule

// File: tb/sync_serial_shifter_test.sv
module sync_serial_shifter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_in = 8'h00;
    logic [7:0] div = 8'd0;
    logic       pol = 1'b0, msb = 1'b0, inv = 1'b0, multi = 1'b0, sel = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo, sclk_a, sclk_b, busy, done;
    logic [7:0] rx_byte;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sync_serial_shifter uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_in), .div_half(div),
        .cfg_pol(pol), .cfg_msb_first(msb), .cfg_invert(inv),
        .cfg_multi_pin(multi), .cfg_pin_sel(sel), .sdi(sdi),
        .sdo(sdo), .sclk_a(sclk_a), .sclk_b(sclk_b), .busy(busy), .done(done),
        .rx_byte(rx_byte)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bpos(input int k, input logic m);
        return m ? 7 - k : k;
    endfunction

    // Slave model state
    logic [7:0] tx_next, s_next, tx_act, s_act, cap;
    logic       in_x = 1'b0, done_prev = 1'b0, prev_lvl, prev_sdo, last_exp = 1'b1;
    int bcnt, cyc, nlead, ntrail;
    bit half_bad, pin_bad, sdo_bad;

    // Slave: follows the selected clock pin, feeds sdi, captures sdo.
    always @(negedge clk) begin
        logic act_lvl, oth_lvl, idle;
        int h;
        if (rst_n) begin
            h       = int'(div) + 1;
            idle    = ~pol;
            act_lvl = (multi && sel) ? sclk_b : sclk_a;
            oth_lvl = (multi && sel) ? sclk_a : sclk_b;
            if (done_prev) chk(done == 1'b0, "R8 done width", done, 0);
            done_prev = done;
            if (busy && !in_x) begin
                in_x = 1'b1; bcnt = 1; cyc = 0; nlead = 0; ntrail = 0; cap = 8'h00;
                half_bad = 0; pin_bad = 0; sdo_bad = 0;
                s_act = s_next; tx_act = tx_next; prev_lvl = idle; prev_sdo = sdo;
            end else if (in_x) begin
                if (busy) bcnt++;
                cyc++;
                if (oth_lvl != idle) pin_bad = 1;
                if (act_lvl != prev_lvl) begin
                    if (cyc != h) half_bad = 1;
                    cyc = 0;
                    if (act_lvl != idle) begin
                        if (nlead < 8) sdi = s_act[bpos(nlead, msb)] ^ inv;
                        nlead++;
                    end else begin
                        if (ntrail < 8) cap[bpos(ntrail, msb)] = sdo ^ inv;
                        ntrail++;
                    end
                end else if (sdo != prev_sdo) begin
                    sdo_bad = 1;
                end
                prev_lvl = act_lvl;
                prev_sdo = sdo;
                if (done) begin
                    string dtag;
                    dtag = inv ? "R6" : (msb ? "R5" : "R4");
                    chk(!busy, "R1 busy low at done", busy, 0);
                    chk(bcnt == 16 * h, "R1 busy length", bcnt, 16 * h);
                    chk(nlead == 8 && ntrail == 8, "R1 edge count", nlead * 100 + ntrail, 808);
                    chk(!half_bad, "R2 half period", 1, 0);
                    chk(!pin_bad, "R7 unselected pin idle", 1, 0);
                    chk(!sdo_bad, "R3 sdo only on launch edge", 1, 0);
                    chk(cap == tx_act, {dtag, " tx bits"}, cap, tx_act);
                    chk(rx_byte == s_act, {dtag, " rx byte R8"}, rx_byte, s_act);
                    last_exp = tx_act[bpos(7, msb)] ^ inv;
                    chk(sdo == last_exp, "R10 last bit", sdo, last_exp);
                    in_x = 1'b0;
                end
            end
        end
    end

    task automatic run_xfer(input logic [7:0] t, input logic [7:0] s, input logic p,
                            input logic m, input logic i, input logic mu, input logic se,
                            input logic [7:0] d, input bit poke, input bit b2b,
                            input logic [7:0] t2, input logic [7:0] s2);
        pol = p; msb = m; inv = i; multi = mu; sel = se; div = d;
        tx_next = t; s_next = s; tx_in = t;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3 * (int'(d) + 1)) @(negedge clk);
            tx_in = ~t;               // R9: must not replace the running byte
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        if (b2b) begin
            tx_next = t2; s_next = s2; tx_in = t2;
            start = 1'b1;             // R11: start in the done cycle
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R11 back-to-back start", busy, 1);
            while (!done) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(sclk_a == ~p && sclk_b == ~p, "R3 idle clock level", {sclk_a, sclk_b}, {~p, ~p});
        chk(sdo == last_exp, "R10 sdo held between transfers", sdo, last_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sdo == 1'b1, "R10 reset sdo", sdo, 1);
        chk(!busy && !done, "R10 reset flags", {busy, done}, 0);
        chk(rx_byte == 8'h00, "R10 reset rx", rx_byte, 0);
        chk(sclk_a && sclk_b, "R10 reset pins idle", {sclk_a, sclk_b}, 2'b11);
        // Directed corner cases
        run_xfer(8'hA5, 8'h3C, 0, 0, 0, 0, 0, 8'd1, 0, 0, 0, 0);   // R4
        run_xfer(8'h81, 8'hC3, 1, 1, 0, 1, 1, 8'd0, 0, 0, 0, 0);   // R5, R7 pin b
        run_xfer(8'h0F, 8'h5A, 0, 0, 1, 1, 0, 8'd2, 1, 0, 0, 0);   // R6, R9
        run_xfer(8'hF0, 8'h12, 1, 0, 1, 0, 1, 8'd0, 0, 1, 8'h69, 8'hE7); // R11
        run_xfer(8'h01, 8'hFE, 0, 1, 1, 1, 1, 8'd5, 1, 1, 8'h80, 8'h7F); // R2
        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [31:0] r;
            r = $urandom;
            run_xfer(8'($urandom), 8'($urandom), r[0], r[1], r[2], r[3], r[4],
                     8'(r[6:5]), r[7], r[8], 8'($urandom), 8'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule